// File: doc/BRIEF.md
# Single-Wire Bus Transaction Sequencer

This block is the device-side controller of a half-duplex, single-wire serial bus. A frame receiver hands it whole bytes from the host, and a frame transmitter accepts bytes from it for sending. The block turns these bytes into transactions. In a write, the host sends an instruction and then a run of data bytes. In a read, the host sends an instruction and the device then returns a run of register bytes. A read can be followed at once by the host's next instruction.

All device-side spacing is counted in bit times. The turn-around before the first read byte and the gap between read bytes each last one bit time. The length of a bit time is set on an input, in clock cycles. The device sleeps until a break condition wakes it. While it is awake, host silence is bounded by a cycle-count limit. When that limit runs out, the device abandons the transaction, returns to sleep and throws away any write bytes it has collected.

Writes are held in a small buffer and reach the register file only once the last data byte has arrived. A line-enable output is high only while the device owns the wire.

Top module: `sbts_seq`

## Requirements
- R1: Reset (asynchronous, active low) puts the device to sleep: `awake`, `tx_valid`, `line_oe` and `reg_we` are all low.
- R2: While asleep, host frames have no effect. A `brk` pulse makes `awake` rise on the next cycle.
- R3: A `brk` while awake does not change the transaction in progress. It does restart the host idle window.
- R4: Instruction byte layout: bits [7:6] are the opcode (01 = write, 10 = read), bits [5:3] are the byte count minus one, and bits [2:0] are the start address. A frame with any other opcode is dropped, and the device stays awake waiting for an instruction.
- R5: A write stores nothing until all of its data bytes have arrived. From the cycle after the last data byte, the device pulses `reg_we` once per cycle for each byte, in arrival order, at consecutive addresses modulo 8.
- R6: After a read instruction is taken, `tx_valid` stays low for exactly `bit_cycles` cycles (a value of 0 counts as 1) and rises on the next cycle.
- R7: Read byte i is the register content at (start + i) modulo 8. `tx_valid` and `tx_data` hold steady until `tx_ready` is seen.
- R8: Between the `tx_done` cycle of one read byte and the `tx_valid` of the next, exactly `bit_cycles` cycles pass (0 counts as 1).
- R9: `line_oe` is high from the cycle after a byte is accepted through its `tx_done` cycle, and never together with `tx_valid`. Host frames that arrive while the device owns the bus are dropped.
- R10: If, while waiting for an instruction or a write data byte, no frame and no break arrive for `TIMEOUT_CYC` cycles in a row, the device falls asleep and a partial write is discarded. A frame in the last cycle of the window is still taken.
- R11: The cycle after the final `tx_done` of a read, the device accepts a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_cycles | input | BT_W | Clock cycles per bit time |
| brk | input | 1 | Break condition detected on the line |
| rx_valid | input | 1 | A received host frame is present this cycle |
| rx_data | input | 8 | Received host byte |
| tx_valid | output | 1 | Request to send a byte |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_done | input | 1 | Transmitter finished the current byte |
| line_oe | output | 1 | Device drives the wire |
| reg_addr | output | ADDR_W | Register file address (read and write) |
| reg_rdata | input | 8 | Register file read data |
| reg_we | output | 1 | Register file write strobe |
| reg_wdata | output | 8 | Register file write data |
| awake | output | 1 | Device is out of sleep |

## Verification
Two functions can land in the same cycle: the expiry of the host idle window and the arrival of a host frame or break. The bench creates that clash by staying silent for exactly `TIMEOUT_CYC`-1 cycles and then sending a one-byte write instruction in the final cycle of the window. The outcome is judged by the write committing and `awake` staying high. A second case places a break inside the window and checks that sleep comes exactly one full window after the break, not after the first silence.

// File: rtl/sbts_pkg.sv
package sbts_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_IDLE,
    ST_WDATA,
    ST_WCOMMIT,
    ST_TURN,
    ST_TXREQ,
    ST_XFER,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/sbts_bit_timer.sv
// Down-counter for one device bit time; expired is high once the count is spent.
module sbts_bit_timer #(
  parameter int BT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BT_W-1:0] bit_cycles,
  output logic            expired
);
  logic [BT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = (bit_cycles == '0) ? '0 : bit_cycles - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sbts_idle_watch.sv
// Counts silent cycles while armed; expire flags the last cycle of the window.
module sbts_idle_watch #(
  parameter int LIMIT = 80_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic activity,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!armed || activity) begin
      if (cnt_q != '0) begin
        cnt_en = 1'b1;
        cnt_d  = '0;
      end
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = armed && !activity && (cnt_q == LAST);
endmodule

// File: rtl/sbts_wbuf.sv
// Holding store for write bytes until the whole burst has arrived.
module sbts_wbuf #(
  parameter int LEN_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LEN_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LEN_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << LEN_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sbts_seq.sv
module sbts_seq
  import sbts_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int LEN_W       = 3,
  parameter int BT_W        = 16,
  parameter int TIMEOUT_CYC = 80_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BT_W-1:0]   bit_cycles,
  input  logic              brk,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              tx_done,
  output logic              line_oe,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              awake
);
  localparam int OP_LSB = ADDR_W + LEN_W;

  seq_state_t        state_q, state_d;
  logic [LEN_W-1:0]  len_q, len_d, idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              field_en, idx_en;
  logic              tmr_load, tmr_expired;
  logic              wd_armed, wd_activity, wd_expire;
  logic              buf_we;
  logic [1:0]        op;
  logic              idx_last;

  assign op       = rx_data[OP_LSB +: 2];
  assign len_d    = rx_data[ADDR_W +: LEN_W];
  assign base_d   = rx_data[ADDR_W-1:0];
  assign idx_last = (idx_q == len_q);

  sbts_bit_timer #(.BT_W(BT_W)) u_bit_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (tmr_load),
    .bit_cycles (bit_cycles),
    .expired    (tmr_expired)
  );

  assign wd_armed    = (state_q == ST_IDLE) || (state_q == ST_WDATA);
  assign wd_activity = rx_valid || brk;

  sbts_idle_watch #(.LIMIT(TIMEOUT_CYC)) u_idle_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (wd_armed),
    .activity (wd_activity),
    .expire   (wd_expire)
  );

  sbts_wbuf #(.LEN_W(LEN_W), .DATA_W(BYTE_W)) u_wbuf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (idx_q),
    .wdata (rx_data),
    .raddr (idx_q),
    .rdata (reg_wdata)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    field_en = 1'b0;
    tmr_load = 1'b0;
    buf_we   = 1'b0;
    case (state_q)
      ST_SLEEP: begin
        if (brk) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (rx_valid) begin
          if (op == OP_WRITE) begin
            state_d  = ST_WDATA;
            field_en = 1'b1;
            idx_en   = 1'b1;
            idx_d    = '0;
          end else if (op == OP_READ) begin
            state_d  = ST_TURN;
            field_en = 1'b1;
            idx_en   = 1'b1;
            idx_d    = '0;
            tmr_load = 1'b1;
          end
        end else if (wd_expire) begin
          state_d = ST_SLEEP;
        end
      end
      ST_WDATA: begin
        if (rx_valid) begin
          buf_we = 1'b1;
          idx_en = 1'b1;
          if (idx_last) begin
            state_d = ST_WCOMMIT;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if (wd_expire) begin
          state_d = ST_SLEEP;
        end
      end
      ST_WCOMMIT: begin
        idx_en = 1'b1;
        if (idx_last) begin
          state_d = ST_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_TURN: begin
        if (tmr_expired) state_d = ST_TXREQ;
      end
      ST_TXREQ: begin
        if (tx_ready) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (tx_done) begin
          if (idx_last) begin
            state_d = ST_IDLE;
          end else begin
            state_d  = ST_GAP;
            tmr_load = 1'b1;
            idx_en   = 1'b1;
            idx_d    = idx_q + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tmr_expired) state_d = ST_TXREQ;
      end
      default: state_d = ST_SLEEP;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SLEEP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      base_q <= '0;
    end else if (field_en) begin
      len_q  <= len_d;
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // Outputs
  assign tx_valid = (state_q == ST_TXREQ);
  assign line_oe  = (state_q == ST_XFER);
  assign reg_we   = (state_q == ST_WCOMMIT);
  assign awake    = (state_q != ST_SLEEP);
  assign reg_addr = base_q + ADDR_W'(idx_q);
  assign tx_data  = reg_rdata;
endmodule

// File: rtl/sbts_seq_chk.sv
module sbts_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brk,
  input logic       rx_valid,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       tx_done,
  input logic       line_oe,
  input logic       reg_we,
  input logic       awake
);
  p_oe_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !tx_valid);

  p_oe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe && !tx_done |=> line_oe);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_asleep_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> !tx_valid && !line_oe && !reg_we);

  p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !awake && brk |=> awake);

  p_brk_harmless_r3: assert property (@(posedge clk) disable iff (!rst_n)
    awake && brk |=> awake);

  p_frame_keeps_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    awake && rx_valid |=> awake);

  p_commit_after_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_we) |-> $past(rx_valid));
endmodule

bind sbts_seq sbts_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .brk      (brk),
  .rx_valid (rx_valid),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .tx_ready (tx_ready),
  .tx_done  (tx_done),
  .line_oe  (line_oe),
  .reg_we   (reg_we),
  .awake    (awake)
);

// File: tb/tb_sbts_seq.sv
module tb_sbts_seq;
  localparam int TO    = 40;
  localparam int FRAME = 4;
  // {intrude, stall, brk, gap[3:0], bit_cycles[7:0], instr[7:0]}
  localparam logic [23:0] VEC [9] = '{
    24'h000051, 24'h000191, 24'h13005E, 24'h20039E, 24'h400080,
    24'h010078, 24'h0005BC, 24'h000045, 24'h000285
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bit_cycles;
  logic        brk, rx_valid, tx_ready, tx_done;
  logic [7:0]  rx_data;
  logic        tx_valid, line_oe, reg_we, awake;
  logic [7:0]  tx_data, reg_rdata, reg_wdata;
  logic [2:0]  reg_addr;
  logic [7:0]  regmem [8];
  logic [7:0]  model  [8];
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sbts_seq #(.TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n), .bit_cycles(bit_cycles), .brk(brk),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .tx_done(tx_done),
    .line_oe(line_oe), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .awake(awake)
  );

  assign reg_rdata = regmem[reg_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regmem[i] <= 8'h30 + 8'(i * 7);
    end else if (reg_we) begin
      regmem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  function automatic logic [7:0] wdat(input logic [7:0] instr, input int i);
    return instr ^ 8'(i * 8'h3B) ^ 8'hC6;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; brk = 0; rx_valid = 0; rx_data = 0; tx_ready = 1; tx_done = 0;
    bit_cycles = 16'd1;
    for (int i = 0; i < 8; i++) model[i] = 8'h30 + 8'(i * 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wake();
    brk = 1'b1;
    @(negedge clk);
    brk = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] instr, input int gap, input bit with_brk);
    int len;
    int base;
    len  = int'(instr[5:3]);
    base = int'(instr[2:0]);
    rx_valid = 1'b1; rx_data = instr;
    @(negedge clk);
    for (int i = 0; i <= len; i++) begin
      rx_valid = 1'b0;
      for (int g = 0; g < gap; g++) begin
        chk(!reg_we && awake, "R5 no write before last byte", {31'd0, reg_we}, 0);
        @(negedge clk);
      end
      brk = with_brk && (i == 1);
      rx_valid = 1'b1; rx_data = wdat(instr, i);
      @(negedge clk);
      brk = 1'b0;
    end
    rx_valid = 1'b0;
    for (int i = 0; i <= len; i++) begin
      logic [2:0] ea;
      ea = 3'(base + i);
      chk(reg_we && reg_addr == ea && reg_wdata == wdat(instr, i),
          with_brk ? "R3 break mid-write, commit" : "R5 commit byte",
          {20'd0, reg_we, reg_addr, reg_wdata}, {20'd0, 1'b1, ea, wdat(instr, i)});
      model[ea] = wdat(instr, i);
      @(negedge clk);
    end
    chk(!reg_we && awake, "R5 commit length", {31'd0, reg_we}, 0);
  endtask

  task automatic do_read(input logic [7:0] instr, input int bc, input bit stall, input bit intrude);
    int len;
    int base;
    int cnt;
    int expb;
    bit oe_bad;
    len  = int'(instr[5:3]);
    base = int'(instr[2:0]);
    expb = (bc == 0) ? 1 : bc;
    oe_bad = 1'b0;
    bit_cycles = 16'(bc);
    rx_valid = 1'b1; rx_data = instr;
    @(negedge clk);
    rx_valid = 1'b0;
    cnt = 0;
    while (!tx_valid && cnt < 500) begin
      if (line_oe) oe_bad = 1'b1;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == expb, "R6 turn-around length", cnt, expb);
    for (int i = 0; i <= len; i++) begin
      logic [2:0] ea;
      ea = 3'(base + i);
      if (i > 0) begin
        cnt = 0;
        while (!tx_valid && cnt < 500) begin
          if (line_oe) oe_bad = 1'b1;
          cnt++;
          @(negedge clk);
        end
        chk(cnt == expb, "R8 inter-frame gap", cnt, expb);
      end
      chk(tx_valid && tx_data == model[ea], "R7 read data", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, model[ea]});
      if (line_oe) oe_bad = 1'b1;
      if (stall && i == 0) begin
        tx_ready = 1'b0;
        @(negedge clk);
        chk(tx_valid && !line_oe && tx_data == model[ea], "R7 hold while not ready",
            {22'd0, tx_valid, line_oe, tx_data}, {22'd0, 2'b10, model[ea]});
        tx_ready = 1'b1;
      end
      @(negedge clk);
      chk(line_oe && !tx_valid, "R9 drive after accept", {30'd0, line_oe, tx_valid}, 2);
      if (intrude && i == 0) begin
        rx_valid = 1'b1; rx_data = 8'h47;
      end
      for (int f = 1; f < FRAME; f++) begin
        if (!line_oe) oe_bad = 1'b1;
        @(negedge clk);
      end
      rx_valid = 1'b0;
      if (!line_oe) oe_bad = 1'b1;
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
    end
    chk(!oe_bad, "R9 line enable only during frames", {31'd0, oe_bad}, 0);
    chk(!line_oe && !tx_valid && !reg_we && awake, intrude ? "R9 host frame dropped" : "R11 back to idle",
        {28'd0, line_oe, tx_valid, reg_we, awake}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    bit ok;
    do_reset();
    chk(!awake && !tx_valid && !line_oe && !reg_we, "R1 reset state",
        {28'd0, awake, tx_valid, line_oe, reg_we}, 0);

    // R2: frames ignored while asleep
    rx_valid = 1'b1; rx_data = 8'h40; @(negedge clk);
    rx_data = 8'hEE; @(negedge clk);
    rx_valid = 1'b0;
    ok = 1'b1;
    repeat (4) begin
      if (awake || reg_we || tx_valid) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R2 asleep ignores frames", {31'd0, ok}, 1);
    wake();
    chk(awake, "R2 break wakes", {31'd0, awake}, 1);

    // Vector table walk
    for (int v = 0; v < 9; v++) begin
      logic [23:0] e;
      e = VEC[v];
      if (e[7:6] == 2'b01) do_write(e[7:0], int'(e[19:16]), e[20]);
      else                 do_read(e[7:0], int'(e[15:8]), e[21], e[22]);
    end

    // R4: unknown opcodes dropped
    rx_valid = 1'b1; rx_data = 8'hC3; @(negedge clk);
    rx_data = 8'h07; @(negedge clk);
    rx_valid = 1'b0;
    ok = 1'b1;
    repeat (4) begin
      if (!awake || reg_we || tx_valid || line_oe) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R4 unknown opcode dropped", {31'd0, ok}, 1);
    do_read(8'h80, 1, 1'b0, 1'b0);

    // R10: idle window from the first idle cycle
    ok = 1'b1;
    for (int k = 1; k <= TO; k++) begin
      if (!awake) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok && !awake, "R10 idle timeout to sleep", {30'd0, ok, awake}, 2);

    // R3: break while awake restarts the window
    wake();
    ok = 1'b1;
    for (int k = 1; k <= TO + 30; k++) begin
      brk = (k == 30);
      if (!awake) ok = 1'b0;
      @(negedge clk);
    end
    brk = 1'b0;
    chk(ok && !awake, "R3 break restarts idle window", {30'd0, ok, awake}, 2);

    // R10: partial write discarded on timeout
    wake();
    rx_valid = 1'b1; rx_data = 8'h5A; @(negedge clk);
    rx_data = 8'h11; @(negedge clk);
    rx_data = 8'h22; @(negedge clk);
    rx_valid = 1'b0;
    ok = 1'b1;
    for (int k = 1; k <= TO; k++) begin
      if (!awake || reg_we) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok && !awake, "R10 partial write timeout", {30'd0, ok, awake}, 2);
    wake();
    do_read(8'h9A, 1, 1'b0, 1'b0);

    // R10: frame in the last cycle of the window is taken
    repeat (TO - 1) @(negedge clk);
    chk(awake, "R10 still awake before window end", {31'd0, awake}, 1);
    do_write(8'h43, 0, 1'b0);
    chk(awake, "R10 last-cycle frame accepted", {31'd0, awake}, 1);

    // R1: reset during a read
    bit_cycles = 16'd2;
    rx_valid = 1'b1; rx_data = 8'h98; @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk(!awake && !tx_valid && !line_oe && !reg_we, "R1 reset mid-read",
        {28'd0, awake, tx_valid, line_oe, reg_we}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule